// File: doc/BRIEF.md
# SECDED Word Guard with Stuck-Lane Detection

This block protects 64-bit memory words with 8 check bits. On the write side a purely combinational generator turns the data word into the check byte, and the two are stored together as a 72-bit word. On the read side the stored word passes through a decoder. The decoder repairs any single flipped bit on its way through and refuses to repair a double flip. It also recognises the pattern left by a failed memory device, where one 4-bit lane of the stored word reads back as all zeros or all ones. Each result carries the corrected data, a 2-bit status, the raw syndrome for an error logger, and, when a single error was repaired, a request to a scrubbing agent to write the clean word back.

The code uses odd-weight columns. Each check bit has a weight-1 column. The data bits take every weight-3 pattern in ascending numeric order, then the lowest weight-5 patterns. A nonzero syndrome of even weight, or an odd syndrome that matches no column, cannot be corrected. The read path is a single registered stage with a valid/ready handshake on both sides. The stage takes a word when `rd_valid_i` and `rd_ready_o` are both high. The stored word on `rd_valid_i`, `rd_data_i` and `rd_check_i` must be held stable until it is taken. A result stays on the outputs, without change, for as long as `rd_valid_o` is high and `rd_ready_i` is low. `rd_ready_o` is high when the stage is empty or its result is being consumed in the same cycle, so full throughput is one word per cycle. The status, syndrome, fatal, lane and scrub outputs are meaningful only while `rd_valid_o` is high.

Top module: `ecc_word_guard`

## Requirements
- R1: `wr_check_o` is a linear function of `wr_data_i` with all-zero check bits for all-zero data, and the stored word is {check byte in bits 71:64, data in bits 63:0}. A word read back exactly as written gives status 2'b00, syndrome 0, and the data unchanged.
- R2: A single flipped data bit is repaired in the same pass. The result shows status 2'b01 with the original data.
- R3: A single flipped check bit gives status 2'b01. The data output equals the input data, and the syndrome is the one-hot of that check bit.
- R4: Any two flipped bits give status 2'b10 when no lane is uniform. The data passes through unmodified and `rd_fatal_o` is high.
- R5: An uncorrectable word in which some 4-bit lane (lane k = stored bits 4k+3:4k) is all ones or all zeros gives status 2'b11. `rd_stuck_lane_o` holds the lowest such k, the data is unmodified, and `rd_fatal_o` is high.
- R6: The lane check applies only when the syndrome is nonzero. A clean word full of uniform lanes, such as all zeros, reports status 2'b00.
- R7: `scrub_req_o` is high exactly while a valid result carries status 2'b01.
- R8: A result appears on the outputs, with `rd_valid_o` high, in the cycle after the input is taken. `rd_valid_o` is low after reset and when no word was sent.
- R9: While `rd_valid_o` is high and `rd_ready_i` is low, every result output holds and `rd_ready_o` is low. A waiting input word is taken on the cycle that `rd_ready_i` returns.
- R10: The check column of each data bit has odd weight of at least 3, and no two data bits share a column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data_i | input | 64 | Data word to be written |
| wr_check_o | output | 8 | Check byte for `wr_data_i` |
| rd_valid_i | input | 1 | Stored word on the read inputs is valid |
| rd_ready_o | output | 1 | Read stage can take a word this cycle |
| rd_data_i | input | 64 | Stored data bits 63:0 |
| rd_check_i | input | 8 | Stored check bits 71:64 |
| rd_valid_o | output | 1 | Result valid |
| rd_ready_i | input | 1 | Consumer takes the result |
| rd_data_o | output | 64 | Corrected or passed-through data |
| rd_status_o | output | 2 | 00 clean, 01 corrected, 10 uncorrectable, 11 stuck lane |
| rd_syndrome_o | output | 8 | Syndrome for logging |
| rd_fatal_o | output | 1 | Valid result is uncorrectable (status 10 or 11) |
| rd_stuck_lane_o | output | 5 | Lowest uniform lane when status is 11, else 0 |
| scrub_req_o | output | 1 | Request to write the corrected word back |

## Verification
The bench flips check bits as well as data bits. A decoder that keys on the data columns alone would then report an uncorrectable error, or corrupt a data bit, on a check-bit fault. The bench sends clean all-zero and all-ones words. A lane detector not gated by the syndrome would call these stuck devices. The bench builds double errors that happen to leave a lane uniform, next to ones that do not. Swapped priority between the uncorrectable and stuck statuses, or a wrong lane index, then shows as a wrong status or index. A held result under back-pressure catches a stage that overwrites its output or drops the waiting word.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;
  localparam int DATA_W   = 64;
  localparam int CHK_W    = 8;
  localparam int WORD_W   = DATA_W + CHK_W;
  localparam int LANE_W   = 4;
  localparam int N_LANES  = WORD_W / LANE_W;
  localparam int LANE_IDX_W = $clog2(N_LANES);

  typedef logic [CHK_W-1:0] col_t;
  typedef col_t [DATA_W-1:0] col_tab_t;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_FATAL = 2'b10,
    ST_STUCK = 2'b11
  } rd_status_e;

  // Data columns: odd weights from 3 upward, ascending value within a weight.
  function automatic col_tab_t build_col_tab();
    col_tab_t tab;
    int n;
    tab = '0;
    n = 0;
    for (int w = 3; w <= CHK_W; w += 2) begin
      for (int v = 0; v < (1 << CHK_W); v++) begin
        if (n < DATA_W && $countones(v[CHK_W-1:0]) == w) begin
          tab[n] = v[CHK_W-1:0];
          n++;
        end
      end
    end
    return tab;
  endfunction

  localparam col_tab_t H_COLS = build_col_tab();
endpackage

// File: rtl/ecc_chk_gen.sv
module ecc_chk_gen
  import ecc_guard_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  always_comb begin
    chk_o = '0;
    for (int i = 0; i < DATA_W; i++) begin
      for (int j = 0; j < CHK_W; j++) begin
        if (H_COLS[i][j]) chk_o[j] = chk_o[j] ^ data_i[i];
      end
    end
  end
endmodule

// File: rtl/ecc_err_locator.sv
module ecc_err_locator
  import ecc_guard_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [CHK_W-1:0]  syndrome_o,
  output logic [DATA_W-1:0] fixed_o,
  output logic              correctable_o,
  output logic              nonzero_o
);
  logic [CHK_W-1:0]  recomputed;
  logic [DATA_W-1:0] hit;
  logic              odd_w;
  logic              chk_only;

  ecc_chk_gen u_regen (
    .data_i (data_i),
    .chk_o  (recomputed)
  );

  assign syndrome_o = recomputed ^ chk_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_match
    assign hit[i] = (syndrome_o == H_COLS[i]);
  end

  assign odd_w         = ^syndrome_o;
  assign chk_only      = $onehot(syndrome_o);
  assign nonzero_o     = |syndrome_o;
  assign correctable_o = odd_w && (chk_only || (|hit));
  assign fixed_o       = data_i ^ hit;
endmodule

// File: rtl/ecc_lane_watch.sv
module ecc_lane_watch #(
  parameter int LANE_W  = 4,
  parameter int N_LANES = 18,
  parameter int IDX_W   = 5
) (
  input  logic [LANE_W*N_LANES-1:0] word_i,
  output logic                      any_o,
  output logic [IDX_W-1:0]          first_o
);
  logic [N_LANES-1:0] uni;

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    logic [LANE_W-1:0] lane;
    assign lane   = word_i[k*LANE_W +: LANE_W];
    assign uni[k] = (&lane) | ~(|lane);
  end

  assign any_o = |uni;

  always_comb begin
    first_o = '0;
    for (int k = N_LANES - 1; k >= 0; k--) begin
      if (uni[k]) first_o = IDX_W'(k);
    end
  end
endmodule

// File: rtl/ecc_word_guard.sv
module ecc_word_guard
  import ecc_guard_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [CHK_W-1:0]      wr_check_o,
  input  logic                  rd_valid_i,
  output logic                  rd_ready_o,
  input  logic [DATA_W-1:0]     rd_data_i,
  input  logic [CHK_W-1:0]      rd_check_i,
  output logic                  rd_valid_o,
  input  logic                  rd_ready_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic [1:0]            rd_status_o,
  output logic [CHK_W-1:0]      rd_syndrome_o,
  output logic                  rd_fatal_o,
  output logic [LANE_IDX_W-1:0] rd_stuck_lane_o,
  output logic                  scrub_req_o
);
  logic [CHK_W-1:0]      syn_d;
  logic [DATA_W-1:0]     fixed_d;
  logic                  correctable;
  logic                  nonzero;
  logic                  lane_any;
  logic [LANE_IDX_W-1:0] lane_first;
  rd_status_e            st_d;
  logic [DATA_W-1:0]     data_d;
  logic [LANE_IDX_W-1:0] lane_d;
  logic                  take;

  logic                  vld_q;
  rd_status_e            st_q;
  logic [DATA_W-1:0]     data_q;
  logic [CHK_W-1:0]      syn_q;
  logic [LANE_IDX_W-1:0] lane_q;

  ecc_chk_gen u_wr_gen (
    .data_i (wr_data_i),
    .chk_o  (wr_check_o)
  );

  ecc_err_locator u_locate (
    .data_i        (rd_data_i),
    .chk_i         (rd_check_i),
    .syndrome_o    (syn_d),
    .fixed_o       (fixed_d),
    .correctable_o (correctable),
    .nonzero_o     (nonzero)
  );

  ecc_lane_watch #(
    .LANE_W  (LANE_W),
    .N_LANES (N_LANES),
    .IDX_W   (LANE_IDX_W)
  ) u_lanes (
    .word_i  ({rd_check_i, rd_data_i}),
    .any_o   (lane_any),
    .first_o (lane_first)
  );

  always_comb begin
    if (!nonzero)         st_d = ST_CLEAN;
    else if (correctable) st_d = ST_FIXED;
    else if (lane_any)    st_d = ST_STUCK;
    else                  st_d = ST_FATAL;
    data_d = (st_d == ST_FIXED) ? fixed_d : rd_data_i;
    lane_d = (st_d == ST_STUCK) ? lane_first : '0;
  end

  assign rd_ready_o = !vld_q || rd_ready_i;
  assign take       = rd_valid_i && rd_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      st_q   <= ST_CLEAN;
      data_q <= '0;
      syn_q  <= '0;
      lane_q <= '0;
    end else if (take) begin
      vld_q  <= 1'b1;
      st_q   <= st_d;
      data_q <= data_d;
      syn_q  <= syn_d;
      lane_q <= lane_d;
    end else if (rd_ready_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign rd_valid_o      = vld_q;
  assign rd_data_o       = data_q;
  assign rd_status_o     = st_q;
  assign rd_syndrome_o   = syn_q;
  assign rd_stuck_lane_o = lane_q;
  assign rd_fatal_o      = vld_q && st_q[1];
  assign scrub_req_o     = vld_q && (st_q == ST_FIXED);
endmodule

// File: rtl/ecc_word_guard_chk.sv
module ecc_word_guard_chk
  import ecc_guard_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rd_valid_i,
  input logic                  rd_ready_o,
  input logic [DATA_W-1:0]     rd_data_i,
  input logic                  rd_ready_i,
  input logic                  rd_valid_o,
  input logic [DATA_W-1:0]     rd_data_o,
  input logic [1:0]            rd_status_o,
  input logic [CHK_W-1:0]      rd_syndrome_o,
  input logic                  rd_fatal_o,
  input logic [LANE_IDX_W-1:0] rd_stuck_lane_o,
  input logic                  scrub_req_o
);
  logic took;
  assign took = rd_valid_i && rd_ready_o;

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> rd_valid_o); // R8

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o) && $stable(rd_status_o)
      && $stable(rd_syndrome_o) && $stable(rd_stuck_lane_o)); // R9

  AST_NO_READY_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |-> !rd_ready_o); // R9

  AST_CLEAN_ZERO_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && rd_status_o == 2'b00 |-> rd_syndrome_o == '0); // R1

  AST_FIX_AT_MOST_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(took) && rd_status_o == 2'b01 |-> $countones(rd_data_o ^ $past(rd_data_i)) <= 1); // R2

  AST_CHECK_BIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(took) && rd_status_o == 2'b01 && $onehot(rd_syndrome_o)
      |-> rd_data_o == $past(rd_data_i)); // R3

  AST_FATAL_PASSTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(took) && rd_fatal_o |-> rd_data_o == $past(rd_data_i) && rd_status_o[1]); // R4

  AST_LANE_ONLY_WHEN_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && rd_status_o != 2'b11 |-> rd_stuck_lane_o == '0); // R5

  AST_SCRUB_ON_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req_o |-> rd_valid_o && rd_status_o == 2'b01 && rd_syndrome_o != '0); // R7
endmodule

bind ecc_word_guard ecc_word_guard_chk chk_i (.*);

// File: tb/ecc_word_guard_tb_top.sv
module ecc_word_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic [7:0]  wr_check_o;
  logic        rd_valid_i = 1'b0;
  logic        rd_ready_o;
  logic [63:0] rd_data_i = '0;
  logic [7:0]  rd_check_i = '0;
  logic        rd_valid_o;
  logic        rd_ready_i = 1'b1;
  logic [63:0] rd_data_o;
  logic [1:0]  rd_status_o;
  logic [7:0]  rd_syndrome_o;
  logic        rd_fatal_o;
  logic [4:0]  rd_stuck_lane_o;
  logic        scrub_req_o;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  ecc_word_guard dut_i (.*);

  typedef struct packed {
    logic [63:0] d;
    logic [71:0] flip;
    logic [1:0]  cls;   // 0 clean, 1 single, 2 double
  } vec_t;

  localparam int N_VEC = 10;
  localparam vec_t VECS [N_VEC] = '{
    '{64'h1234_5678_9ABC_DE13, 72'h0,                         2'd0}, // R1
    '{64'h1234_5678_9ABC_DE13, 72'h1,                         2'd1}, // R2
    '{64'hA5C3_9E71_2B4D_86E9, 72'h00_8000_0000_0000_0000,    2'd1}, // R2
    '{64'hA5C3_9E71_2B4D_86E9, 72'h20_0000_0000,              2'd1}, // R2
    '{64'h1234_5678_9ABC_DE13, 72'h01_0000_0000_0000_0000,    2'd1}, // R3
    '{64'hA5C3_9E71_2B4D_86E9, 72'h80_0000_0000_0000_0000,    2'd1}, // R3
    '{64'h1234_5678_9ABC_DE13, 72'h0100_0000_0020,            2'd2}, // R4
    '{64'hA5C3_9E71_2B4D_86E9, 72'h04_0000_0000_0000_0004,    2'd2}, // R4
    '{64'h0000_0000_0000_0000, 72'h0,                         2'd0}, // R6
    '{64'hFFFF_FFFF_FFFF_FFFF, 72'h0,                         2'd0}  // R6
  };

  task automatic check(input bit ok, input string tag, input logic [71:0] act,
                       input logic [71:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit lowest_uniform(input logic [71:0] w, output logic [4:0] idx);
    bit found = 0;
    idx = '0;
    for (int k = 17; k >= 0; k--) begin
      if (w[4*k +: 4] == 4'h0 || w[4*k +: 4] == 4'hF) begin
        found = 1;
        idx = 5'(k);
      end
    end
    return found;
  endfunction

  task automatic encode(input logic [63:0] d, output logic [7:0] c);
    wr_data_i = d;
    #1;
    c = wr_check_o;
  endtask

  // Send one stored word with consumer ready; result checked the next cycle.
  task automatic send(input logic [63:0] d, input logic [71:0] flip, input logic [1:0] cls);
    logic [7:0]  c;
    logic [71:0] stored;
    logic [1:0]  es;
    logic [63:0] ed;
    logic [4:0]  el;
    @(negedge clk);
    encode(d, c);
    stored = {c, d} ^ flip;
    rd_data_i  = stored[63:0];
    rd_check_i = stored[71:64];
    rd_valid_i = 1'b1;
    check(rd_ready_o, "R8 ready when idle", 72'(rd_ready_o), 72'd1);
    @(negedge clk);
    rd_valid_i = 1'b0;
    el = '0;
    if (cls == 2'd0) begin
      es = 2'b00; ed = d;
    end else if (cls == 2'd1) begin
      es = 2'b01; ed = d;
    end else begin
      ed = stored[63:0];
      es = lowest_uniform(stored, el) ? 2'b11 : 2'b10;
    end
    check(rd_valid_o == 1'b1, "R8 valid after take", 72'(rd_valid_o), 72'd1);
    check(rd_status_o == es, (cls == 2'd2) ? "R4/R5 status" : "R1/R2 status",
          72'(rd_status_o), 72'(es));
    check(rd_data_o == ed, (cls == 2'd1) ? "R2 corrected data" : "R4 data",
          72'(rd_data_o), 72'(ed));
    check(rd_fatal_o == es[1], "R4 fatal flag", 72'(rd_fatal_o), 72'(es[1]));
    check(scrub_req_o == (es == 2'b01), "R7 scrub request", 72'(scrub_req_o),
          72'(es == 2'b01));
    check(rd_stuck_lane_o == el, "R5 lane index", 72'(rd_stuck_lane_o), 72'(el));
    if (cls == 2'd0)
      check(rd_syndrome_o == 8'h00, "R1 zero syndrome", 72'(rd_syndrome_o), 72'h0);
    if (cls == 2'd1 && flip[71:64] != 8'h00)
      check(rd_syndrome_o == flip[71:64], "R3 one-hot syndrome", 72'(rd_syndrome_o),
            72'(flip[71:64]));
    @(negedge clk);
    check(rd_valid_o == 1'b0, "R8 valid drops", 72'(rd_valid_o), 72'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] cols [64];
    logic [7:0] ca, cb, cab;
    bit distinct;
    logic [7:0] cq;

    repeat (3) @(negedge clk);
    // R8 reset state
    check(rd_valid_o == 1'b0, "R8 reset valid", 72'(rd_valid_o), 72'd0);
    check(scrub_req_o == 1'b0 && rd_fatal_o == 1'b0, "R7 reset flags",
          72'({scrub_req_o, rd_fatal_o}), 72'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(rd_valid_o == 1'b0, "R8 idle valid", 72'(rd_valid_o), 72'd0);

    // R1: zero data encodes to zero; linearity
    encode(64'h0, ca);
    check(ca == 8'h00, "R1 zero check byte", 72'(ca), 72'h0);
    encode(64'h1234_5678_9ABC_DE13, ca);
    encode(64'h0F0F_3C3C_5A5A_6969, cb);
    encode(64'h1234_5678_9ABC_DE13 ^ 64'h0F0F_3C3C_5A5A_6969, cab);
    check(cab == (ca ^ cb), "R1 linear check byte", 72'(cab), 72'(ca ^ cb));

    // R10: per-bit columns odd weight >= 3 and distinct
    for (int i = 0; i < 64; i++) begin
      encode(64'h1 << i, cols[i]);
      check(($countones(cols[i]) % 2 == 1) && ($countones(cols[i]) >= 3),
            "R10 column weight", 72'(cols[i]), 72'h0);
    end
    distinct = 1;
    for (int i = 0; i < 64; i++)
      for (int j = i + 1; j < 64; j++)
        if (cols[i] == cols[j]) distinct = 0;
    check(distinct, "R10 distinct columns", 72'(distinct), 72'd1);

    // Table walk
    for (int v = 0; v < N_VEC; v++) send(VECS[v].d, VECS[v].flip, VECS[v].cls);

    // R5: two bits forced so lane 0 reads all zeros
    send(64'h1234_5678_9ABC_DE13, 72'h3, 2'd2);
    // R5: two bits forced so lane 4 reads all ones
    send(64'h1234_5678_9ABC_DE13, 72'h3_0000, 2'd2);

    // R9: back-pressure
    @(negedge clk);
    rd_ready_i = 1'b0;
    encode(64'h1111_2222_4444_8888, cq);
    rd_data_i = 64'h1111_2222_4444_8888; rd_check_i = cq; rd_valid_i = 1'b1;
    @(negedge clk);
    encode(64'h7654_3210_FEDC_BA98, cq);
    rd_data_i = 64'h7654_3210_FEDC_BA98 ^ 64'h100; rd_check_i = cq;
    check(rd_valid_o && !rd_ready_o, "R9 stalled ready low",
          72'({rd_valid_o, rd_ready_o}), 72'b10);
    @(negedge clk);
    check(rd_data_o == 64'h1111_2222_4444_8888 && rd_status_o == 2'b00,
          "R9 held result", 72'(rd_data_o), 72'h1111_2222_4444_8888);
    rd_ready_i = 1'b1;
    @(negedge clk);
    rd_valid_i = 1'b0;
    check(rd_valid_o && rd_data_o == 64'h7654_3210_FEDC_BA98 && rd_status_o == 2'b01,
          "R9 waiting word taken", 72'(rd_data_o), 72'h7654_3210_FEDC_BA98);
    @(negedge clk);
    check(rd_valid_o == 1'b0, "R9 drained", 72'(rd_valid_o), 72'd0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule